// File: doc/BRIEF.md
# Decode Operand Unit with Register File and Bypass

This block sits in the decode slot of a five-stage pipeline for a small 64-bit load/store instruction set. It holds the architectural register file, with fourteen general registers plus the stack pointer, and performs the writeback stage's register updates itself. Writeback drives two write ports directly: an ALU-result port and a load-result port.

From the decoded instruction code and the two register specifiers, the unit works out which registers the instruction reads and writes. It then produces the two operand values, valA and valB. Each operand comes from the newest in-flight producer, chosen among the execute result, the memory-stage load and ALU results, and the two writeback results. If none of them matches, the operand is read from the register file.

Status, instruction code, function code and the constant pass straight through to the next pipeline register. Pipeline registers and stall control belong to the surrounding pipeline.

Top module: `opunit_top`

## Requirements
- R1: While rstN is low, every register (IDs 0 through 14) clears to zero on the clock edge, so reads after reset return zero and stackPtr is zero.
- R2: A wbDstE other than 0xF writes wbValE into that register on the rising clock edge. A later read with no forwarding match returns the new value.
- R3: A wbDstM other than 0xF writes wbValM into that register on the same edge. It can land together with a wbDstE write to a different register.
- R4: When wbDstE and wbDstM name the same register (not 0xF) in one cycle, the register keeps wbValM.
- R5: Register ID 0xF means "none". It never writes, it never matches a forwarding destination, and an operand whose source is 0xF reads as zero.
- R6: The bypass priority for each operand is as follows, and the register file is used only when no source matches:
  1. exeVal (by exeDst)
  2. memLoadVal (by memDstM)
  3. memValE (by memDstE)
  4. wbValM (by wbDstM)
  5. wbValE (by wbDstE)
- R7: For icode 8 (call) and icode 7 (jump), valA equals inValP, whatever the forwarding inputs hold.
- R8: The codes used are: icodes 2 cmov, 3 irmov, 4 rmmov, 5 mrmov, 6 ALU op, 9 ret, 10 push, 11 pop; stack pointer ID 4. The unit derives register IDs from them:
  - srcA is inRA for 2, 4, 6 and 10; 4 for 9 and 11; 0xF otherwise.
  - srcB is inRB for 4, 5 and 6; 4 for 8, 9, 10 and 11; 0xF otherwise.
  - dstE is inRB for 2, 3 and 6; 4 for 8, 9, 10 and 11; 0xF otherwise.
  - dstM is inRA for 5 and 11; 0xF otherwise.
- R9: stackPtr always shows the contents of register 4, including updates made through either write port.
- R10: outStat, outIcode, outIfun and outValC equal inStat, inIcode, inIfun and inValC combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inStat | input | STAT_W | Status from the fetch/decode register |
| inIcode | input | 4 | Instruction code |
| inIfun | input | 4 | Function code |
| inRA | input | 4 | First register specifier |
| inRB | input | 4 | Second register specifier |
| inValC | input | DATA_W | Constant field |
| inValP | input | DATA_W | Fall-through address |
| exeDst | input | 4 | Execute-stage ALU destination |
| exeVal | input | DATA_W | Execute-stage ALU result |
| memDstE | input | 4 | Memory-stage ALU destination |
| memValE | input | DATA_W | Memory-stage ALU result |
| memDstM | input | 4 | Memory-stage load destination |
| memLoadVal | input | DATA_W | Data read by the memory stage |
| wbDstE | input | 4 | Writeback ALU destination, write port E |
| wbValE | input | DATA_W | Writeback ALU value |
| wbDstM | input | 4 | Writeback load destination, write port M |
| wbValM | input | DATA_W | Writeback load value |
| outStat | output | STAT_W | Status passed through |
| outIcode | output | 4 | Instruction code passed through |
| outIfun | output | 4 | Function code passed through |
| outValC | output | DATA_W | Constant passed through |
| valA | output | DATA_W | First operand |
| valB | output | DATA_W | Second operand |
| srcA | output | 4 | Derived first source ID |
| srcB | output | 4 | Derived second source ID |
| dstE | output | 4 | Derived ALU destination ID |
| dstM | output | 4 | Derived load destination ID |
| stackPtr | output | DATA_W | Contents of register 4 |

## Verification
The bench sweeps all 32 combinations of the five bypass sources matching one register. A design with two priorities swapped returns an older value when two sources collide, for example a memory-stage ALU result shadowing a pending load. Both write ports aim at one register, and a unit that lets the ALU port win leaves a stale value. Destinations of 0xF carry nonzero data, which shows whether "none" is treated as a real register and either writes or forwards junk. The icode sweep and the call/jump cases expose a wrong stack-pointer implication, or a bypass value leaking into the return address operand.

// File: rtl/opunit_pkg.sv
package opunit_pkg;

  localparam int ID_W = 4;
  localparam logic [ID_W-1:0] REG_NONE = 4'hF;
  localparam logic [ID_W-1:0] REG_SP   = 4'h4;

  localparam logic [3:0] OP_CMOV  = 4'd2;
  localparam logic [3:0] OP_IRMOV = 4'd3;
  localparam logic [3:0] OP_RMMOV = 4'd4;
  localparam logic [3:0] OP_MRMOV = 4'd5;
  localparam logic [3:0] OP_ALU   = 4'd6;
  localparam logic [3:0] OP_JUMP  = 4'd7;
  localparam logic [3:0] OP_CALL  = 4'd8;
  localparam logic [3:0] OP_RET   = 4'd9;
  localparam logic [3:0] OP_PUSH  = 4'd10;
  localparam logic [3:0] OP_POP   = 4'd11;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic [ID_W-1:0] srcA;
    logic [ID_W-1:0] srcB;
    logic [ID_W-1:0] dstE;
    logic [ID_W-1:0] dstM;
    logic            useValP;
  } decodeStrobes_t;

endpackage

// File: rtl/opunit_ctrl.sv
module opunit_ctrl
  import opunit_pkg::*;
(
  input  logic [3:0]      icode,
  input  logic [ID_W-1:0] regA,
  input  logic [ID_W-1:0] regB,
  output decodeStrobes_t  strobes
);

  always_comb begin
    strobes = '{srcA: REG_NONE, srcB: REG_NONE, dstE: REG_NONE,
                dstM: REG_NONE, useValP: 1'b0};
    unique case (icode)
      OP_CMOV: begin
        strobes.srcA = regA;
        strobes.dstE = regB;
      end
      OP_IRMOV: strobes.dstE = regB;
      OP_RMMOV: begin
        strobes.srcA = regA;
        strobes.srcB = regB;
      end
      OP_MRMOV: begin
        strobes.srcB = regB;
        strobes.dstM = regA;
      end
      OP_ALU: begin
        strobes.srcA = regA;
        strobes.srcB = regB;
        strobes.dstE = regB;
      end
      OP_JUMP: strobes.useValP = 1'b1;
      OP_CALL: begin
        strobes.useValP = 1'b1;
        strobes.srcB    = REG_SP;
        strobes.dstE    = REG_SP;
      end
      OP_RET: begin
        strobes.srcA = REG_SP;
        strobes.srcB = REG_SP;
        strobes.dstE = REG_SP;
      end
      OP_PUSH: begin
        strobes.srcA = regA;
        strobes.srcB = REG_SP;
        strobes.dstE = REG_SP;
      end
      OP_POP: begin
        strobes.srcA = REG_SP;
        strobes.srcB = REG_SP;
        strobes.dstE = REG_SP;
        strobes.dstM = regA;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opunit_dp.sv
module opunit_dp
  import opunit_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int REG_COUNT = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  decodeStrobes_t       strobes,
  input  logic [DATA_W-1:0]    valP,
  input  logic [ID_W-1:0]      exeDst,
  input  logic [DATA_W-1:0]    exeVal,
  input  logic [ID_W-1:0]      memDstE,
  input  logic [DATA_W-1:0]    memValE,
  input  logic [ID_W-1:0]      memDstM,
  input  logic [DATA_W-1:0]    memLoadVal,
  input  logic [ID_W-1:0]      wbDstE,
  input  logic [DATA_W-1:0]    wbValE,
  input  logic [ID_W-1:0]      wbDstM,
  input  logic [DATA_W-1:0]    wbValM,
  output logic [DATA_W-1:0]    valA,
  output logic [DATA_W-1:0]    valB,
  output logic [DATA_W-1:0]    stackPtr
);

  localparam int PORTS = 2;

  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [PORTS*DATA_W-1:0] opFlat;

  function automatic logic [DATA_W-1:0] readReg(input logic [ID_W-1:0] id);
    if (32'(id) < REG_COUNT) return regFile[id];
    return '0;
  endfunction

  // writeback merged here; port M assigned last so it wins a collision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else begin
      if (wbDstE != REG_NONE && 32'(wbDstE) < REG_COUNT) regFile[wbDstE] <= wbValE;
      if (wbDstM != REG_NONE && 32'(wbDstM) < REG_COUNT) regFile[wbDstM] <= wbValM;
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_operand
      logic [ID_W-1:0]   srcId;
      logic [DATA_W-1:0] picked;
      assign srcId = (p == 0) ? strobes.srcA : strobes.srcB;
      always_comb begin
        if (srcId == REG_NONE)     picked = '0;
        else if (srcId == exeDst)  picked = exeVal;
        else if (srcId == memDstM) picked = memLoadVal;
        else if (srcId == memDstE) picked = memValE;
        else if (srcId == wbDstM)  picked = wbValM;
        else if (srcId == wbDstE)  picked = wbValE;
        else                       picked = readReg(srcId);
      end
      assign opFlat[p*DATA_W +: DATA_W] = picked;
    end
  endgenerate

  assign valA     = strobes.useValP ? valP : opFlat[0 +: DATA_W];
  assign valB     = opFlat[DATA_W +: DATA_W];
  assign stackPtr = regFile[REG_SP];

  assert_porte_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wbDstE != REG_NONE && wbDstE != wbDstM) |=> regFile[$past(wbDstE)] == $past(wbValE));

  assert_portm_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wbDstM != REG_NONE) |=> regFile[$past(wbDstM)] == $past(wbValM));

  assert_collision_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbDstE == wbDstM && wbDstE != REG_NONE) |=> regFile[$past(wbDstE)] == $past(wbValM));

  assert_none_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.srcB == REG_NONE) |-> valB == '0);

  assert_exec_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.useValP && strobes.srcA != REG_NONE && strobes.srcA == exeDst) |-> valA == exeVal);

  assert_valp_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useValP |-> valA == valP);

  assert_sp_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wbDstM == REG_SP) |=> stackPtr == $past(wbValM));

endmodule

// File: rtl/opunit_top.sv
module opunit_top
  import opunit_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] inStat,
  input  logic [3:0]        inIcode,
  input  logic [3:0]        inIfun,
  input  logic [3:0]        inRA,
  input  logic [3:0]        inRB,
  input  logic [DATA_W-1:0] inValC,
  input  logic [DATA_W-1:0] inValP,
  input  logic [3:0]        exeDst,
  input  logic [DATA_W-1:0] exeVal,
  input  logic [3:0]        memDstE,
  input  logic [DATA_W-1:0] memValE,
  input  logic [3:0]        memDstM,
  input  logic [DATA_W-1:0] memLoadVal,
  input  logic [3:0]        wbDstE,
  input  logic [DATA_W-1:0] wbValE,
  input  logic [3:0]        wbDstM,
  input  logic [DATA_W-1:0] wbValM,
  output logic [STAT_W-1:0] outStat,
  output logic [3:0]        outIcode,
  output logic [3:0]        outIfun,
  output logic [DATA_W-1:0] outValC,
  output logic [DATA_W-1:0] valA,
  output logic [DATA_W-1:0] valB,
  output logic [3:0]        srcA,
  output logic [3:0]        srcB,
  output logic [3:0]        dstE,
  output logic [3:0]        dstM,
  output logic [DATA_W-1:0] stackPtr
);

  decodeStrobes_t strobes;

  opunit_ctrl u_ctrl (
    .icode   (inIcode),
    .regA    (inRA),
    .regB    (inRB),
    .strobes (strobes)
  );

  opunit_dp #(.DATA_W(DATA_W), .REG_COUNT(15)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .valP       (inValP),
    .exeDst     (exeDst),
    .exeVal     (exeVal),
    .memDstE    (memDstE),
    .memValE    (memValE),
    .memDstM    (memDstM),
    .memLoadVal (memLoadVal),
    .wbDstE     (wbDstE),
    .wbValE     (wbValE),
    .wbDstM     (wbDstM),
    .wbValM     (wbValM),
    .valA       (valA),
    .valB       (valB),
    .stackPtr   (stackPtr)
  );

  assign srcA     = strobes.srcA;
  assign srcB     = strobes.srcB;
  assign dstE     = strobes.dstE;
  assign dstM     = strobes.dstM;
  assign outStat  = inStat;
  assign outIcode = inIcode;
  assign outIfun  = inIfun;
  assign outValC  = inValC;

  assert_pop_reads_sp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inIcode == OP_POP) |-> (srcA == REG_SP && dstM == inRA));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outIcode == inIcode && outValC == inValC));

endmodule

// File: tb/opunit_top_tb.sv
`timescale 1ns/1ps
module opunit_top_tb;

  localparam logic [3:0] NONE = 4'hF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  inStat = '0;
  logic [3:0]  inIcode = 4'd1, inIfun = '0, inRA = NONE, inRB = NONE;
  logic [63:0] inValC = '0, inValP = '0;
  logic [3:0]  exeDst = NONE, memDstE = NONE, memDstM = NONE, wbDstE = NONE, wbDstM = NONE;
  logic [63:0] exeVal = '0, memValE = '0, memLoadVal = '0, wbValE = '0, wbValM = '0;
  logic [2:0]  outStat;
  logic [3:0]  outIcode, outIfun, srcA, srcB, dstE, dstM;
  logic [63:0] outValC, valA, valB, stackPtr;

  logic [63:0] model [15];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  opunit_top u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // commit writeback to the model at the edge, then return at the falling edge
  task automatic tick();
    @(posedge clk);
    if (rstN) begin
      if (wbDstE != NONE) model[wbDstE] = wbValE;
      if (wbDstM != NONE) model[wbDstM] = wbValM;
    end
    @(negedge clk);
  endtask

  task automatic clearFwd();
    exeDst = NONE; memDstE = NONE; memDstM = NONE; wbDstE = NONE; wbDstM = NONE;
  endtask

  task automatic sweepRegs(input string req);
    inIcode = 4'd6;
    for (int r = 0; r < 15; r++) begin
      inRA = 4'(r); inRB = 4'(r); #1;
      check(req, valA, model[r]);
      check(req, valB, model[r]);
    end
  endtask

  function automatic logic [15:0] expDecode(input logic [3:0] ic, input logic [3:0] ra, input logic [3:0] rb);
    logic [3:0] sa, sb, de, dm;
    sa = NONE; sb = NONE; de = NONE; dm = NONE;
    if (ic == 2 || ic == 4 || ic == 6 || ic == 10) sa = ra;
    if (ic == 9 || ic == 11) sa = 4'd4;
    if (ic == 4 || ic == 5 || ic == 6) sb = rb;
    if (ic >= 8 && ic <= 11) begin sb = 4'd4; de = 4'd4; end
    if (ic == 2 || ic == 3 || ic == 6) de = rb;
    if (ic == 5 || ic == 11) dm = ra;
    return {sa, sb, de, dm};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 15; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    sweepRegs("R1");
    check("R1 stackPtr", stackPtr, 64'd0);

    // R2 / R3: fill all registers using both ports together
    for (int r = 0; r < 15; r += 2) begin
      wbDstE = 4'(r); wbValE = 64'hA000_0000_0000_0000 + 64'(r * 17);
      wbDstM = (r + 1 < 15) ? 4'(r + 1) : NONE;
      wbValM = 64'h5000_0000_0000_0000 + 64'(r * 29);
      tick();
    end
    clearFwd();
    sweepRegs("R2 R3");

    // R4 collision on register 3
    wbDstE = 4'd3; wbValE = 64'hEEEE; wbDstM = 4'd3; wbValM = 64'hBBBB;
    tick();
    clearFwd();
    inIcode = 4'd6; inRA = 4'd3; inRB = 4'd3; #1;
    check("R4", valA, 64'hBBBB);

    // R5 none: no write, no forwarding match, zero read
    wbValE = 64'hDEAD; wbValM = 64'hBEEF; exeVal = 64'h1234;
    tick();
    sweepRegs("R5 nowrite");
    inIcode = 4'd6; inRA = NONE; inRB = NONE; #1;
    check("R5 srcA none", valA, 64'd0);
    check("R5 srcB none", valB, 64'd0);

    // R6 priority sweep over all source combinations on register 2
    for (int mask = 0; mask < 32; mask++) begin
      logic [63:0] vals [5];
      logic [63:0] exp;
      for (int k = 0; k < 5; k++) vals[k] = 64'h100 * 64'(k + 1) + 64'(mask);
      exeDst  = mask[0] ? 4'd2 : 4'd5; exeVal     = vals[0];
      memDstM = mask[1] ? 4'd2 : 4'd5; memLoadVal = vals[1];
      memDstE = mask[2] ? 4'd2 : 4'd5; memValE    = vals[2];
      wbDstM  = mask[3] ? 4'd2 : 4'd5; wbValM     = vals[3];
      wbDstE  = mask[4] ? 4'd2 : 4'd5; wbValE     = vals[4];
      inIcode = 4'd6; inRA = 4'd2; inRB = 4'd2; #1;
      exp = model[2];
      for (int k = 4; k >= 0; k--) if (mask[k]) exp = vals[k];
      check("R6 valA", valA, exp);
      check("R6 valB", valB, exp);
      tick();
    end
    clearFwd();
    sweepRegs("R6 after");

    // R7 call / jump take valP
    exeDst = 4'd4; exeVal = 64'h7777; inValP = 64'h0000_0000_0000_0C0D;
    inIcode = 4'd8; #1;
    check("R7 call", valA, 64'hC0D);
    inIcode = 4'd7; inValP = 64'h4242; #1;
    check("R7 jump", valA, 64'h4242);
    clearFwd();

    // R8 icode sweep
    for (int ic = 0; ic < 16; ic++) begin
      logic [15:0] e;
      inIcode = 4'(ic); inRA = 4'd1; inRB = 4'd6; #1;
      e = expDecode(4'(ic), 4'd1, 4'd6);
      check("R8 srcA", 64'(srcA), 64'(e[15:12]));
      check("R8 srcB", 64'(srcB), 64'(e[11:8]));
      check("R8 dstE", 64'(dstE), 64'(e[7:4]));
      check("R8 dstM", 64'(dstM), 64'(e[3:0]));
    end

    // R9 stack pointer follows both ports
    wbDstE = 4'd4; wbValE = 64'h1111_2222; tick(); clearFwd(); #1;
    check("R9 port E", stackPtr, 64'h1111_2222);
    wbDstM = 4'd4; wbValM = 64'h3333_4444; tick(); clearFwd(); #1;
    check("R9 port M", stackPtr, 64'h3333_4444);

    // R10 pass-through
    inStat = 3'd5; inIcode = 4'd6; inIfun = 4'd3; inValC = 64'hFEED_FACE; #1;
    check("R10 stat", 64'(outStat), 64'd5);
    check("R10 icode", 64'(outIcode), 64'd6);
    check("R10 ifun", 64'(outIfun), 64'd3);
    check("R10 valC", outValC, 64'hFEED_FACE);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule